// File: doc/BRIEF.md
# Prioritized Interrupt Vector Controller

This block collects every interrupt request of a small 8-bit controller and picks the single source that the CPU services next. The sources are fourteen on-chip peripheral requests, an active-low general interrupt pin, an active-low high-priority pin, two nonmaskable traps (software interrupt and illegal opcode), a watchdog request, a clock-failure request and a pending reset-vector fetch. For the winning source the block presents a pending flag and the 16-bit address of its vector-table entry. The CPU confirms the choice with an accept handshake.

The general interrupt mask input blocks all maskable sources. The high-priority pin has its own mask bit, held inside the block. That bit starts set after reset and software can clear it only during a short boot window. The block sets it again whenever it accepts a high-priority pin interrupt, and a strobe reports that action to the CPU. In the same boot window software can switch the general pin from level to falling-edge detection. At any time software can lift one peripheral source to the top of the maskable group.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, `x_mask_o` is 1 and one cycle later `pend_o` is 1 with `vec_o` = 0xFFFE (reset fetch, index 20). Once that is accepted it stays cleared until the next reset.
- R2: For a winning source of index k, `vec_o` = 0xFFD6 + 2*k. Indices: 0 serial comms, 1 serial peripheral, 2 pulse-accumulator edge, 3 pulse-accumulator overflow, 4 timer overflow, 5..9 output compares 5 down to 1, 10..12 input captures 3 down to 1, 13 real-time tick, 14 general pin, 15 high-priority pin, 16 software trap, 17 illegal opcode, 18 watchdog, 19 clock failure, 20 reset. Peripheral k is bit k of `per_req`/`per_en`.
- R3: Among active sources the higher index wins. A peripheral request counts only while its bit in `per_en` is 1.
- R4: `mask_i` = 1 blocks indices 0..14 and has no effect on indices 15..20.
- R5: A write with `cfg_we` stores `cfg_promo` at any time. A value p in 0..13 ranks peripheral p above index 14 and below index 15. The values 14 and 15 leave the fixed order.
- R6: Index 15 is blocked while `x_mask_o` is 1. `cfg_we` with `cfg_x_clear` = 1 clears `x_mask_o` only on the first 64 clock edges after reset is released, and has no effect after that.
- R7: Accepting index 15 sets `x_mask_o` to 1 and raises `x_set_o` for exactly one cycle. Both are visible in the cycle after the accepting edge.
- R8: By default the general pin is level-sensitive. It requests while `irq_n` is 0, and the request survives being accepted.
- R9: `cfg_we` with `cfg_irq_edge` = 1 inside the 64-edge window makes the general pin falling-edge sensitive. Each falling edge latches one request, which is visible on `pend_o` two cycles after the edge and is cleared when accepted. Writes after the window do not change the mode.
- R10: An accept takes place on the first edge at which `ack_i` is 1 while `pend_o` is 1. `pend_o` and `vec_o` hold their values for as long as `ack_i` stays 1. Otherwise they follow the requests with one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| per_req | input | 14 | Peripheral request lines, bit = source index |
| per_en | input | 14 | Local enable per peripheral request |
| irq_n | input | 1 | General interrupt pin, active low |
| xirq_n | input | 1 | High-priority interrupt pin, active low, level |
| swi_req | input | 1 | Software-interrupt trap request |
| illop_req | input | 1 | Illegal-opcode trap request |
| cop_req | input | 1 | Watchdog time-out request |
| clkmon_req | input | 1 | Clock-failure request |
| mask_i | input | 1 | General interrupt mask |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_irq_edge | input | 1 | Requested edge mode for the general pin |
| cfg_x_clear | input | 1 | Request to clear the high-priority mask |
| cfg_promo | input | 4 | Source index to promote |
| ack_i | input | 1 | Accept handshake from the CPU |
| pend_o | output | 1 | A source is waiting for service |
| vec_o | output | 16 | Vector-table address of the winner |
| x_set_o | output | 1 | One-cycle pulse: mask set by hardware |
| x_mask_o | output | 1 | Current high-priority mask bit |

## Verification
Arbitration is swept over every ordered pair of maskable sources under each of the 16 promote values. A wrong promoted rank or a wrong fixed order shows up there as a wrong vector. A second sweep covers every pair of the twenty external sources, which tells apart nonmaskable ranking and the mask gating. Single-source sweeps with the enables off and with `mask_i` set separate gating from ranking. Directed sequences cover the boot-window writes both inside and after the window, the level and edge behaviour across an accept, the hardware mask set, and vector hold while the handshake is open.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
   // count of sources ranked above the maskable group
   localparam int HI_COUNT = 6;

   // slot order inside the nonmaskable group, lowest rank first
   typedef enum logic [2:0] {
      HI_XPIN   = 3'd0,
      HI_SWTRAP = 3'd1,
      HI_BADOP  = 3'd2,
      HI_WDOG   = 3'd3,
      HI_CLKF   = 3'd4,
      HI_BOOT   = 3'd5
   } hi_slot_e;

   typedef struct packed {
      logic irq_edge;
      logic x_clear;
   } ivc_cfg_t;

   function automatic int vec_addr(int base, int idx);
      return base + 2 * idx;
   endfunction
endpackage

// File: rtl/ivc_boot_window.sv
module ivc_boot_window
   import ivc_pkg::*;
#(
   parameter int WIN_CYCLES = 64
)(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     cfg_we,
   input  ivc_cfg_t cfg,
   input  logic     xirq_taken,
   output logic     win_open,
   output logic     edge_mode,
   output logic     x_bit
);
   localparam int CNT_W = $clog2(WIN_CYCLES + 1);

   if (WIN_CYCLES < 1) begin : g_bad_win
      $error("ivc_boot_window: WIN_CYCLES must be positive");
   end

   logic [CNT_W-1:0] cnt;

   assign win_open = (cnt < CNT_W'(WIN_CYCLES));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt <= '0;
      else if (win_open) cnt <= cnt + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   edge_mode <= 1'b0;
      else if (cfg_we && win_open)  edge_mode <= cfg.irq_edge;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                x_bit <= 1'b1;
      else if (xirq_taken)                       x_bit <= 1'b1;
      else if (cfg_we && win_open && cfg.x_clear) x_bit <= 1'b0;
   end

   // R6
   x_clear_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(x_bit) |-> $past(win_open));

   // R9
   edge_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !win_open |=> $stable(edge_mode));

   // R7
   x_reset_by_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xirq_taken |=> x_bit);
endmodule

// File: rtl/ivc_irq_pin.sv
module ivc_irq_pin (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_n,
   input  logic edge_mode,
   input  logic clear,
   output logic req
);
   logic pin_q;
   logic caught;
   logic fall;

   assign fall = pin_q && !pin_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pin_q <= 1'b1;
      else        pin_q <= pin_n;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  caught <= 1'b0;
      else if (edge_mode && fall)  caught <= 1'b1;
      else if (clear)              caught <= 1'b0;
   end

   assign req = edge_mode ? caught : !pin_n;

   // R9
   edge_needs_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(caught) |-> $past(edge_mode) && !$past(pin_n));
endmodule

// File: rtl/ivc_arbiter.sv
module ivc_arbiter #(
   parameter int N_LO    = 15,
   parameter int N_HI    = 6,
   parameter int IDX_W   = 5,
   parameter int PROMO_W = 4
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_LO-1:0]    req_lo,
   input  logic [N_HI-1:0]    req_hi,
   input  logic               mask_i,
   input  logic [PROMO_W-1:0] promo,
   output logic               valid,
   output logic [IDX_W-1:0]   idx
);
   localparam int EXT_N = 2 ** PROMO_W;

   if (EXT_N < N_LO + 1) begin : g_bad_promo
      $error("ivc_arbiter: PROMO_W too narrow for N_LO");
   end
   if (2 ** IDX_W < N_LO + N_HI) begin : g_bad_idx
      $error("ivc_arbiter: IDX_W too narrow");
   end

   logic [EXT_N-1:0] lo_ext;
   logic             promo_hit;

   always_comb begin
      lo_ext = '0;
      lo_ext[N_LO-1:0] = req_lo;
   end

   // the top entry of the maskable group never needs promotion
   assign promo_hit = !mask_i && (int'(promo) < N_LO - 1) && lo_ext[promo];

   always_comb begin
      valid = 1'b0;
      idx   = '0;
      if (!mask_i) begin
         for (int k = 0; k < N_LO; k++) begin
            if (req_lo[k]) begin
               valid = 1'b1;
               idx   = IDX_W'(k);
            end
         end
      end
      if (promo_hit) begin
         valid = 1'b1;
         idx   = IDX_W'(promo);
      end
      for (int k = 0; k < N_HI; k++) begin
         if (req_hi[k]) begin
            valid = 1'b1;
            idx   = IDX_W'(N_LO + k);
         end
      end
   end

   // R4
   mask_blocks_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_i && valid) |-> (int'(idx) >= N_LO));

   // R3
   winner_requests_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && int'(idx) < N_LO) |-> lo_ext[idx]);
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
   import ivc_pkg::*;
#(
   parameter int  N_PERIPH   = 14,
   parameter int  WIN_CYCLES = 64,
   parameter int  ADDR_W     = 16,
   parameter int  VEC_BASE   = 'hFFD6,
   localparam int PROMO_W    = $clog2(N_PERIPH + 2)
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic [N_PERIPH-1:0] per_req,
   input  logic [N_PERIPH-1:0] per_en,
   input  logic                irq_n,
   input  logic                xirq_n,
   input  logic                swi_req,
   input  logic                illop_req,
   input  logic                cop_req,
   input  logic                clkmon_req,
   input  logic                mask_i,
   input  logic                cfg_we,
   input  logic                cfg_irq_edge,
   input  logic                cfg_x_clear,
   input  logic [PROMO_W-1:0]  cfg_promo,
   input  logic                ack_i,
   output logic                pend_o,
   output logic [ADDR_W-1:0]   vec_o,
   output logic                x_set_o,
   output logic                x_mask_o
);
   localparam int N_LO      = N_PERIPH + 1;
   localparam int NSRC      = N_LO + HI_COUNT;
   localparam int IDX_W     = $clog2(NSRC);
   localparam int IDX_IRQ   = N_PERIPH;
   localparam int IDX_XIRQ  = N_LO + int'(HI_XPIN);
   localparam int IDX_BOOT  = N_LO + int'(HI_BOOT);

   if (N_PERIPH < 1 || N_PERIPH > 30) begin : g_bad_n
      $error("irq_vector_ctrl: N_PERIPH out of range");
   end
   if (VEC_BASE + 2 * (NSRC - 1) >= 2 ** ADDR_W) begin : g_bad_base
      $error("irq_vector_ctrl: vector table overruns address space");
   end
   if (VEC_BASE % 2 != 0) begin : g_bad_align
      $error("irq_vector_ctrl: VEC_BASE must be even");
   end

   logic [N_LO-1:0]     req_lo;
   logic [HI_COUNT-1:0] req_hi;
   logic                irq_req;
   logic                win_open;
   logic                edge_mode;
   logic                x_bit;
   logic                win_valid;
   logic [IDX_W-1:0]    win_idx;
   logic [ADDR_W-1:0]   vec_next;
   logic [PROMO_W-1:0]  promo_q;
   logic                pend_q;
   logic [IDX_W-1:0]    idx_q;
   logic [ADDR_W-1:0]   vec_q;
   logic                ack_q;
   logic                x_set_q;
   logic                boot_pend;
   logic                accept;
   logic                take_x;
   logic                take_irq;
   logic                take_boot;
   ivc_cfg_t            cfg;

   assign cfg.irq_edge = cfg_irq_edge;
   assign cfg.x_clear  = cfg_x_clear;

   assign accept    = ack_i && !ack_q && pend_q;
   assign take_x    = accept && (int'(idx_q) == IDX_XIRQ);
   assign take_irq  = accept && (int'(idx_q) == IDX_IRQ);
   assign take_boot = accept && (int'(idx_q) == IDX_BOOT);

   ivc_boot_window #(
      .WIN_CYCLES (WIN_CYCLES)
   ) u_win (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_we     (cfg_we),
      .cfg        (cfg),
      .xirq_taken (take_x),
      .win_open   (win_open),
      .edge_mode  (edge_mode),
      .x_bit      (x_bit)
   );

   ivc_irq_pin u_pin (
      .clk       (clk),
      .rst_n     (rst_n),
      .pin_n     (irq_n),
      .edge_mode (edge_mode),
      .clear     (take_irq),
      .req       (irq_req)
   );

   // peripheral requests gated by their local enables
   for (genvar g = 0; g < N_PERIPH; g++) begin : g_per
      assign req_lo[g] = per_req[g] && per_en[g];
   end
   assign req_lo[IDX_IRQ] = irq_req;

   assign req_hi[HI_XPIN]   = !xirq_n && !x_bit;
   assign req_hi[HI_SWTRAP] = swi_req;
   assign req_hi[HI_BADOP]  = illop_req;
   assign req_hi[HI_WDOG]   = cop_req;
   assign req_hi[HI_CLKF]   = clkmon_req;
   assign req_hi[HI_BOOT]   = boot_pend;

   ivc_arbiter #(
      .N_LO    (N_LO),
      .N_HI    (HI_COUNT),
      .IDX_W   (IDX_W),
      .PROMO_W (PROMO_W)
   ) u_arb (
      .clk    (clk),
      .rst_n  (rst_n),
      .req_lo (req_lo),
      .req_hi (req_hi),
      .mask_i (mask_i),
      .promo  (promo_q),
      .valid  (win_valid),
      .idx    (win_idx)
   );

   assign vec_next = ADDR_W'(vec_addr(VEC_BASE, int'(win_idx)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      promo_q <= PROMO_W'(IDX_IRQ);
      else if (cfg_we) promo_q <= cfg_promo;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         idx_q  <= '0;
         vec_q  <= ADDR_W'(VEC_BASE);
      end else if (!ack_i) begin
         pend_q <= win_valid;
         idx_q  <= win_idx;
         vec_q  <= vec_next;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack_q     <= 1'b0;
         x_set_q   <= 1'b0;
         boot_pend <= 1'b1;
      end else begin
         ack_q   <= ack_i;
         x_set_q <= take_x;
         if (take_boot) boot_pend <= 1'b0;
      end
   end

   assign pend_o   = pend_q;
   assign vec_o    = vec_q;
   assign x_set_o  = x_set_q;
   assign x_mask_o = x_bit;

   // R10
   hold_during_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && ack_q) |-> ($stable(vec_o) && $stable(pend_o)));

   // R7
   x_set_pairs_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      x_set_o |-> x_mask_o);

   // R6
   xpin_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (win_valid && int'(win_idx) == IDX_XIRQ) |-> !x_mask_o);

   // R2
   vec_in_table_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pend_o |-> (!vec_o[0] && vec_o >= ADDR_W'(VEC_BASE)));

   // R1
   boot_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !boot_pend |=> !boot_pend);
endmodule

// File: tb/sim_irq_vector_ctrl.sv
`timescale 1ns/1ps
module sim_irq_vector_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [13:0] per_req = '0;
   logic [13:0] per_en = '1;
   logic        irq_n = 1'b1;
   logic        xirq_n = 1'b1;
   logic        swi_req = 1'b0;
   logic        illop_req = 1'b0;
   logic        cop_req = 1'b0;
   logic        clkmon_req = 1'b0;
   logic        mask_i = 1'b0;
   logic        cfg_we = 1'b0;
   logic        cfg_irq_edge = 1'b0;
   logic        cfg_x_clear = 1'b0;
   logic [3:0]  cfg_promo = 4'd15;
   logic        ack_i = 1'b0;
   logic        pend_o;
   logic [15:0] vec_o;
   logic        x_set_o;
   logic        x_mask_o;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   irq_vector_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .per_req(per_req), .per_en(per_en),
      .irq_n(irq_n), .xirq_n(xirq_n), .swi_req(swi_req), .illop_req(illop_req),
      .cop_req(cop_req), .clkmon_req(clkmon_req), .mask_i(mask_i),
      .cfg_we(cfg_we), .cfg_irq_edge(cfg_irq_edge), .cfg_x_clear(cfg_x_clear),
      .cfg_promo(cfg_promo), .ack_i(ack_i), .pend_o(pend_o), .vec_o(vec_o),
      .x_set_o(x_set_o), .x_mask_o(x_mask_o)
   );

   task automatic chk(string tag, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // request vector: bit k = source index k (0..19)
   task automatic set_reqs(logic [19:0] r);
      per_req    = r[13:0];
      irq_n      = !r[14];
      xirq_n     = !r[15];
      swi_req    = r[16];
      illop_req  = r[17];
      cop_req    = r[18];
      clkmon_req = r[19];
   endtask

   function automatic int exp_win(logic [19:0] r, logic mi, logic xm, int p);
      for (int k = 19; k >= 16; k--) if (r[k]) return k;
      if (r[15] && !xm) return 15;
      if (mi) return -1;
      if (p <= 13 && r[p]) return p;
      for (int k = 14; k >= 0; k--) if (r[k]) return k;
      return -1;
   endfunction

   task automatic chk_win(string tag, int e);
      chk({tag, " pend"}, int'(pend_o), (e >= 0) ? 1 : 0);
      if (e >= 0) chk({tag, " vec"}, int'(vec_o), 'hFFD6 + 2 * e);
   endtask

   task automatic cfg_write(logic edge_v, logic xclr, logic [3:0] p);
      cfg_irq_edge = edge_v; cfg_x_clear = xclr; cfg_promo = p; cfg_we = 1'b1;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic do_accept();
      ack_i = 1'b1;
      @(negedge clk);
      ack_i = 1'b0;
      @(negedge clk);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      set_reqs('0);
      repeat (3) @(negedge clk);
      // R1: mask state while reset is held
      chk("R1 x_mask in reset", int'(x_mask_o), 1);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      #(4 * 190000);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      // ---------- first reset, level mode, mask cleared in window ----------
      do_reset();
      chk_win("R1 boot fetch", 20);
      cfg_write(1'b0, 1'b1, 4'd15);
      chk("R6 clear in window", int'(x_mask_o), 0);
      do_accept();
      chk_win("R1 boot consumed", -1);

      // R2/R3 single peripheral sweep, enabled and disabled
      for (int i = 0; i < 14; i++) begin
         set_reqs(20'(1) << i);
         @(negedge clk);
         chk_win("R2 single periph", i);
         per_en = ~(14'(1) << i);
         @(negedge clk);
         chk_win("R3 disabled periph", -1);
         per_en = '1;
      end

      // R4 mask sweep over all external sources
      mask_i = 1'b1;
      for (int i = 0; i < 20; i++) begin
         set_reqs(20'(1) << i);
         @(negedge clk);
         chk_win("R4 masked single", exp_win(20'(1) << i, 1'b1, 1'b0, 15));
      end
      mask_i = 1'b0;

      // R5 every promote value against every maskable pair
      for (int p = 0; p < 16; p++) begin
         set_reqs('0);
         cfg_write(1'b0, 1'b0, 4'(p));
         for (int a = 0; a < 15; a++) begin
            for (int b = 0; b < 15; b++) begin
               logic [19:0] r;
               r = (20'(1) << a) | (20'(1) << b);
               set_reqs(r);
               @(negedge clk);
               chk_win("R5 promote pair", exp_win(r, 1'b0, 1'b0, p));
            end
         end
      end
      cfg_write(1'b0, 1'b0, 4'd15);

      // R3 pairs across the whole external range, both mask settings
      for (int m = 0; m < 2; m++) begin
         mask_i = m[0];
         for (int a = 0; a < 20; a++) begin
            for (int b = 0; b < 20; b++) begin
               logic [19:0] r;
               r = (20'(1) << a) | (20'(1) << b);
               set_reqs(r);
               @(negedge clk);
               chk_win("R3 fixed pair", exp_win(r, m[0], 1'b0, 15));
            end
         end
      end
      mask_i = 1'b0;

      // R10 vector held while handshake is open
      set_reqs(20'(1) << 3);
      @(negedge clk);
      chk_win("R10 before ack", 3);
      ack_i = 1'b1;
      set_reqs(20'(1) << 19);
      @(negedge clk);
      chk_win("R10 held 1", 3);
      @(negedge clk);
      chk_win("R10 held 2", 3);
      ack_i = 1'b0;
      @(negedge clk);
      chk_win("R10 released", 19);
      set_reqs('0);
      @(negedge clk);

      // R9 edge write after window ignored; R8 level survives accept
      cfg_write(1'b1, 1'b0, 4'd15);
      set_reqs(20'(1) << 14);
      @(negedge clk);
      chk_win("R8 level pin", 14);
      do_accept();
      chk_win("R8 level kept after accept", 14);
      chk_win("R9 late edge write ignored", 14);
      set_reqs('0);
      @(negedge clk);

      // R7 hardware sets mask on high-priority accept
      set_reqs(20'(1) << 15);
      @(negedge clk);
      chk_win("R6 xpin open", 15);
      ack_i = 1'b1;
      @(negedge clk);
      chk("R7 x_set pulse", int'(x_set_o), 1);
      chk("R7 mask set", int'(x_mask_o), 1);
      ack_i = 1'b0;
      @(negedge clk);
      chk("R7 pulse one cycle", int'(x_set_o), 0);
      chk_win("R6 xpin now blocked", -1);
      cfg_write(1'b0, 1'b1, 4'd15);
      @(negedge clk);
      chk("R6 late clear ignored", int'(x_mask_o), 1);
      chk_win("R6 xpin still blocked", -1);
      set_reqs('0);

      // ---------- second reset: edge mode ----------
      do_reset();
      cfg_write(1'b1, 1'b0, 4'd15);
      do_accept();
      chk_win("R1 boot consumed 2", -1);
      irq_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      chk_win("R9 edge caught", 14);
      do_accept();
      chk_win("R9 cleared though pin low", -1);
      irq_n = 1'b1;
      @(negedge clk);
      irq_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      chk_win("R9 second edge", 14);
      do_accept();
      irq_n = 1'b1;
      xirq_n = 1'b0;
      @(negedge clk);
      chk_win("R6 mask stays set", -1);
      chk("R6 mask value", int'(x_mask_o), 1);
      xirq_n = 1'b1;

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule